// File: doc/BRIEF.md
# ADC Result Holding Register Bank

This block keeps the conversion results that an ADC controller produces for a set of sample slots. Each time the converter finishes, it presents a 12-bit result, a slot number and a one-cycle done strobe. The bank stores the result in that slot, marks it valid and flags an overrun when unread data is overwritten. Software reads a slot through a combinational read port. A read strobe consumes the entry, which clears its valid and overrun flags on the next clock edge.

A per-slot mode input selects double buffering. A slot in this mode holds two results as a small queue. The main read word always shows the older result. An auxiliary word shows the newer one, with its own valid flag. A packed status vector mirrors every slot's valid and overrun flags. Two global bits report whether any slot holds data and whether any slot has overrun.

Top module: `adc_result_hold`

## Requirements
- R1: `rd_word` for the slot on `rd_slot` carries the held result in bits 11:0, the overrun flag in bit 16 and the valid flag in bit 17. All other bits are 0.
- R2: A `cnv_done` pulse stores `cnv_data` in slot `cnv_slot`. From the next cycle that slot's valid flag reads 1 and its data field holds the value.
- R3: In single-buffer mode, a `rd_strobe` on a valid slot, with no write to that slot in the same cycle, clears the slot's valid flag in the next cycle.
- R4: In single-buffer mode, a write to a slot that already holds an unread result sets the overrun flag and replaces the data with the newest result.
- R5: A read strobe clears the slot's overrun flag on the same edge that consumes the entry. The overrun flag is never 1 while the slot's valid flag is 0.
- R6: With `dbuf_en[i]`=1, slot i holds two results without overrun. `rd_word` shows the older result. `rd_aux_word` shows the newer result in bits 11:0, with its valid flag in bit 16 and 0 in all other bits.
- R7: In double-buffer mode, a write to a slot that already holds two unread results replaces the newer buffer, keeps the older one and sets overrun.
- R8: In double-buffer mode, a read with two results held makes the newer result the head. It clears the auxiliary valid flag and the overrun flag.
- R9: When a read strobe and a write hit the same slot in the same cycle, the write wins. Valid stays 1 and overrun is not set. In single-buffer mode the new data replaces the read entry. In double-buffer mode with two results held, the older result is consumed and the new one queues behind the remaining result.
- R10: `stat_word` bits N-1:0 mirror the slots' valid flags and bits 2N-1:N mirror their overrun flags. Bit index equals slot number.
- R11: `any_valid` is 1 exactly while some slot is valid. `any_ovr` is 1 exactly while some slot has overrun.
- R12: After a synchronous reset, every slot is empty with data 0. All status outputs are 0.
- R13: A write or read to one slot leaves every other slot's flags and data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnv_done | input | 1 | Conversion-done strobe |
| cnv_slot | input | SLOT_W | Slot that receives the result |
| cnv_data | input | 12 | Conversion result |
| dbuf_en | input | NUM_SLOTS | Per-slot double-buffer mode |
| rd_strobe | input | 1 | Consume the entry at `rd_slot` |
| rd_slot | input | SLOT_W | Slot shown on the read words |
| rd_word | output | 32 | Head result word of the selected slot |
| rd_aux_word | output | 32 | Second-buffer word of the selected slot |
| stat_word | output | 2*NUM_SLOTS | Valid flags (low half) and overrun flags (high half) |
| any_valid | output | 1 | Some slot holds data |
| any_ovr | output | 1 | Some slot has overrun |

## Verification
The key overlap is a software read strobe and a conversion write that land on the same slot in the same clock. The bench provokes it directly in single-buffer mode and in double-buffer mode with both buffers full. It also generates it often in a randomized phase that confines reads and writes to a few slots. Every outcome is scored against an independent slot model built from the requirements. The model predicts that the write survives, valid stays set, no overrun appears and, in double-buffer mode, the older entry is consumed.

// File: rtl/adc_hold_pkg.sv
package adc_hold_pkg;

    localparam int RES_W       = 12;
    localparam int WORD_W      = 32;
    localparam int OVR_POS     = 16;
    localparam int VLD_POS     = 17;
    localparam int AUX_VLD_POS = 16;

    typedef logic [RES_W-1:0] result_t;

    // Per-slot storage: two result buffers, fill level and sticky overrun
    typedef struct packed {
        result_t    buf_old;
        result_t    buf_new;
        logic [1:0] level;
        logic       ovr;
    } slot_state_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_BOTH  = 2'b11
    } slot_op_e;

    function automatic logic [WORD_W-1:0] pack_head(input logic vld,
                                                    input logic ovr,
                                                    input result_t data);
        logic [WORD_W-1:0] w;
        w = '0;
        w[RES_W-1:0] = data;
        w[OVR_POS]   = ovr;
        w[VLD_POS]   = vld;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] pack_aux(input logic vld,
                                                   input result_t data);
        logic [WORD_W-1:0] w;
        w = '0;
        w[RES_W-1:0]     = data;
        w[AUX_VLD_POS]   = vld;
        return w;
    endfunction

endpackage

// File: rtl/adc_hold_decode.sv
module adc_hold_decode #(
    parameter int NUM_SLOTS = 16,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 wr_en,
    input  logic [SLOT_W-1:0]    wr_idx,
    input  logic                 rd_en,
    input  logic [SLOT_W-1:0]    rd_idx,
    output logic [NUM_SLOTS-1:0] wr_hit,
    output logic [NUM_SLOTS-1:0] rd_hit
);
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_dec
        assign wr_hit[i] = wr_en && (wr_idx == SLOT_W'(i));
        assign rd_hit[i] = rd_en && (rd_idx == SLOT_W'(i));
    end
endmodule

// File: rtl/adc_hold_slot.sv
module adc_hold_slot
    import adc_hold_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    dbl,
    input  logic    wr,
    input  result_t wr_data,
    input  logic    rd,
    output result_t head_data,
    output logic    head_valid,
    output result_t tail_data,
    output logic    tail_valid,
    output logic    ovr
);
    slot_state_t cur, nxt;
    logic [1:0]  cap;
    slot_op_e    op;

    assign cap = dbl ? 2'd2 : 2'd1;
    assign op  = slot_op_e'({wr, rd});

    always_comb begin
        nxt = cur;
        unique case (op)
            OP_BOTH: begin
                // write wins: entry consumed and refilled in one edge
                nxt.ovr = 1'b0;
                if (cur.level == 2'd2) begin
                    nxt.buf_old = cur.buf_new;
                    nxt.buf_new = wr_data;
                end else begin
                    nxt.buf_old = wr_data;
                    nxt.level   = 2'd1;
                end
            end
            OP_WRITE: begin
                if (cur.level < cap) begin
                    if (cur.level == 2'd0) nxt.buf_old = wr_data;
                    else                   nxt.buf_new = wr_data;
                    nxt.level = 2'(cur.level + 2'd1);
                end else begin
                    if (cur.level == 2'd2) nxt.buf_new = wr_data;
                    else                   nxt.buf_old = wr_data;
                    nxt.ovr = 1'b1;
                end
            end
            OP_READ: begin
                nxt.ovr = 1'b0;
                if (cur.level == 2'd2) begin
                    nxt.buf_old = cur.buf_new;
                    nxt.level   = 2'd1;
                end else begin
                    nxt.level   = 2'd0;
                end
            end
            default: nxt = cur;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign head_data  = cur.buf_old;
    assign head_valid = (cur.level != 2'd0);
    assign tail_data  = cur.buf_new;
    assign tail_valid = (cur.level == 2'd2);
    assign ovr        = cur.ovr;

    assert_wr_sets_valid_R2: assert property (@(posedge clk) disable iff (rst)
        wr |=> head_valid);
    assert_rd_clears_valid_R3: assert property (@(posedge clk) disable iff (rst)
        rd && !wr && !tail_valid |=> !head_valid);
    assert_single_overrun_R4: assert property (@(posedge clk) disable iff (rst)
        wr && !rd && !dbl && head_valid |=> ovr);
    assert_rd_clears_ovr_R5: assert property (@(posedge clk) disable iff (rst)
        rd && !wr |=> !ovr);
    assert_ovr_needs_data_R5: assert property (@(posedge clk) disable iff (rst)
        ovr |-> head_valid);
    assert_tail_behind_head_R6: assert property (@(posedge clk) disable iff (rst)
        tail_valid |-> head_valid);
    assert_dbl_no_early_ovr_R7: assert property (@(posedge clk) disable iff (rst)
        dbl && wr && !rd && !tail_valid && !ovr |=> !ovr);
    assert_collision_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
        wr && rd |=> head_valid && !ovr);
endmodule

// File: rtl/adc_hold_status.sv
module adc_hold_status #(
    parameter int NUM_SLOTS = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_SLOTS-1:0]   vld_vec,
    input  logic [NUM_SLOTS-1:0]   ovr_vec,
    output logic [2*NUM_SLOTS-1:0] stat_word,
    output logic                   any_valid,
    output logic                   any_ovr
);
    assign stat_word = {ovr_vec, vld_vec};
    assign any_valid = |vld_vec;
    assign any_ovr   = |ovr_vec;

    assert_ovr_implies_valid_R11: assert property (@(posedge clk) disable iff (rst)
        any_ovr |-> any_valid);
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold
    import adc_hold_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cnv_done,
    input  logic [SLOT_W-1:0]      cnv_slot,
    input  logic [RES_W-1:0]       cnv_data,
    input  logic [NUM_SLOTS-1:0]   dbuf_en,
    input  logic                   rd_strobe,
    input  logic [SLOT_W-1:0]      rd_slot,
    output logic [WORD_W-1:0]      rd_word,
    output logic [WORD_W-1:0]      rd_aux_word,
    output logic [2*NUM_SLOTS-1:0] stat_word,
    output logic                   any_valid,
    output logic                   any_ovr
);
    logic [NUM_SLOTS-1:0] wr_hit, rd_hit;
    logic [NUM_SLOTS-1:0] vld_vec, tail_vec, ovr_vec;
    result_t              head_arr [NUM_SLOTS];
    result_t              tail_arr [NUM_SLOTS];

    adc_hold_decode #(.NUM_SLOTS(NUM_SLOTS)) u_dec (
        .wr_en  (cnv_done),
        .wr_idx (cnv_slot),
        .rd_en  (rd_strobe),
        .rd_idx (rd_slot),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit)
    );

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        adc_hold_slot u_slot (
            .clk        (clk),
            .rst        (rst),
            .dbl        (dbuf_en[i]),
            .wr         (wr_hit[i]),
            .wr_data    (cnv_data),
            .rd         (rd_hit[i]),
            .head_data  (head_arr[i]),
            .head_valid (vld_vec[i]),
            .tail_data  (tail_arr[i]),
            .tail_valid (tail_vec[i]),
            .ovr        (ovr_vec[i])
        );
    end

    always_comb begin
        rd_word     = pack_head(vld_vec[rd_slot], ovr_vec[rd_slot], head_arr[rd_slot]);
        rd_aux_word = pack_aux(tail_vec[rd_slot], tail_arr[rd_slot]);
    end

    adc_hold_status #(.NUM_SLOTS(NUM_SLOTS)) u_stat (
        .clk       (clk),
        .rst       (rst),
        .vld_vec   (vld_vec),
        .ovr_vec   (ovr_vec),
        .stat_word (stat_word),
        .any_valid (any_valid),
        .any_ovr   (any_ovr)
    );

    assert_reset_empty_R12: assert property (@(posedge clk)
        $past(rst) |-> !any_valid && !any_ovr);
    assert_status_other_slot_R13: assert property (@(posedge clk) disable iff (rst)
        !cnv_done && !rd_strobe |=> $stable(stat_word));
endmodule

// File: tb/tb_adc_result_hold.sv
module tb_adc_result_hold;
    localparam int N  = 16;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cnv_done = 1'b0;
    logic [SW-1:0] cnv_slot = '0;
    logic [11:0]   cnv_data = '0;
    logic [N-1:0]  dbuf_en = '0;
    logic          rd_strobe = 1'b0;
    logic [SW-1:0] rd_slot = '0;
    logic [31:0]   rd_word, rd_aux_word;
    logic [2*N-1:0] stat_word;
    logic          any_valid, any_ovr;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    adc_result_hold #(.NUM_SLOTS(N)) dut (
        .clk(clk), .rst(rst), .cnv_done(cnv_done), .cnv_slot(cnv_slot),
        .cnv_data(cnv_data), .dbuf_en(dbuf_en), .rd_strobe(rd_strobe),
        .rd_slot(rd_slot), .rd_word(rd_word), .rd_aux_word(rd_aux_word),
        .stat_word(stat_word), .any_valid(any_valid), .any_ovr(any_ovr)
    );

    // reference slot model, written from the requirements
    int          m_lvl [N];
    logic        m_ovr [N];
    logic [11:0] m_old [N];
    logic [11:0] m_new [N];

    typedef struct {
        string       tag;
        logic [31:0] w;
        logic [31:0] a;
        logic [2*N-1:0] st;
        logic        av;
        logic        ao;
    } exp_t;
    exp_t sb_q[$];

    function automatic logic [31:0] mk_head(logic v, logic o, logic [11:0] d);
        return {14'b0, v, o, 4'b0, d};
    endfunction
    function automatic logic [31:0] mk_aux(logic v, logic [11:0] d);
        return {15'b0, v, 4'b0, d};
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_lvl[i] = 0; m_ovr[i] = 1'b0; m_old[i] = '0; m_new[i] = '0;
        end
    endtask

    task automatic model_step(bit w, int ws, logic [11:0] d, bit r, int rs);
        for (int i = 0; i < N; i++) begin
            bit wi = w && (ws == i);
            bit ri = r && (rs == i);
            int cap = dbuf_en[i] ? 2 : 1;
            if (wi && ri) begin
                m_ovr[i] = 1'b0;
                if (m_lvl[i] == 2) begin m_old[i] = m_new[i]; m_new[i] = d; end
                else begin m_old[i] = d; m_lvl[i] = 1; end
            end else if (wi) begin
                if (m_lvl[i] < cap) begin
                    if (m_lvl[i] == 0) m_old[i] = d; else m_new[i] = d;
                    m_lvl[i]++;
                end else begin
                    if (m_lvl[i] == 2) m_new[i] = d; else m_old[i] = d;
                    m_ovr[i] = 1'b1;
                end
            end else if (ri) begin
                m_ovr[i] = 1'b0;
                if (m_lvl[i] == 2) begin m_old[i] = m_new[i]; m_lvl[i] = 1; end
                else m_lvl[i] = 0;
            end
        end
    endtask

    // driver: one operation cycle, then inputs return idle
    task automatic op(bit w, int ws, logic [11:0] d, bit r, int rs);
        @(negedge clk);
        cnv_done = w; cnv_slot = SW'(ws); cnv_data = d;
        rd_strobe = r; rd_slot = SW'(rs);
        @(posedge clk);
        model_step(w, ws, d, r, rs);
        #1;
        cnv_done = 1'b0; rd_strobe = 1'b0;
    endtask

    // driver: select a slot and queue the expected view
    task automatic expect_slot(string tag, int s);
        exp_t e;
        logic [2*N-1:0] st;
        rd_slot = SW'(s);
        #1;
        for (int i = 0; i < N; i++) begin
            st[i]   = (m_lvl[i] != 0);
            st[N+i] = m_ovr[i];
        end
        e.tag = tag;
        e.w   = mk_head(m_lvl[s] != 0, m_ovr[s], m_old[s]);
        e.a   = mk_aux(m_lvl[s] == 2, m_new[s]);
        e.st  = st;
        e.av  = |st[N-1:0];
        e.ao  = |st[2*N-1:N];
        sb_q.push_back(e);
        #1;
    endtask

    // monitor: pops expected items and compares against the ports
    initial begin
        exp_t e;
        forever begin
            wait (sb_q.size() != 0);
            e = sb_q.pop_front();
            checks++;
            if (rd_word !== e.w) begin
                failures++;
                $display("FAIL %s rd_word actual=%h expected=%h", e.tag, rd_word, e.w);
            end
            checks++;
            if (rd_aux_word !== e.a) begin
                failures++;
                $display("FAIL %s rd_aux_word actual=%h expected=%h", e.tag, rd_aux_word, e.a);
            end
            checks++;
            if (stat_word !== e.st || any_valid !== e.av || any_ovr !== e.ao) begin
                failures++;
                $display("FAIL %s status actual=%h/%b/%b expected=%h/%b/%b", e.tag,
                         stat_word, any_valid, any_ovr, e.st, e.av, e.ao);
            end
        end
    end

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        expect_slot("R12", 0);
        expect_slot("R12", 5);

        // single buffer basics
        op(1, 3, 12'hABC, 0, 0);
        expect_slot("R2", 3);
        expect_slot("R1", 3);
        expect_slot("R13", 4);
        op(0, 0, 0, 1, 3);
        expect_slot("R3", 3);
        op(1, 3, 12'h111, 0, 0);
        op(1, 3, 12'h222, 0, 0);
        expect_slot("R4", 3);
        expect_slot("R11", 0);
        expect_slot("R10", 3);
        op(0, 0, 0, 1, 3);
        expect_slot("R5", 3);

        // double buffer
        dbuf_en[7] = 1'b1;
        op(1, 7, 12'h100, 0, 0);
        op(1, 7, 12'h200, 0, 0);
        expect_slot("R6", 7);
        op(1, 7, 12'h300, 0, 0);
        expect_slot("R7", 7);
        op(0, 0, 0, 1, 7);
        expect_slot("R8", 7);
        op(0, 0, 0, 1, 7);
        expect_slot("R8", 7);

        // same-cycle read and write
        op(1, 9, 12'h055, 0, 0);
        op(1, 9, 12'h066, 1, 9);
        expect_slot("R9", 9);
        op(1, 7, 12'h0A1, 0, 0);
        op(1, 7, 12'h0A2, 0, 0);
        op(1, 7, 12'h0A3, 1, 7);
        expect_slot("R9", 7);
        op(1, 2, 12'hFFF, 1, 5);
        expect_slot("R13", 2);
        expect_slot("R13", 5);

        // drain and confirm globals drop
        op(0, 0, 0, 1, 9);
        op(0, 0, 0, 1, 7);
        op(0, 0, 0, 1, 7);
        op(0, 0, 0, 1, 2);
        op(0, 0, 0, 1, 3);
        expect_slot("R11", 0);

        // mixed traffic on a few slots, two of them double-buffered
        dbuf_en = 16'h000A;
        for (int k = 0; k < 400; k++) begin
            int ws = $urandom_range(0, 3);
            int rs = $urandom_range(0, 3);
            bit w  = ($urandom_range(0, 3) != 0);
            bit r  = ($urandom_range(0, 2) == 0);
            op(w, ws, 12'($urandom), r, rs);
            expect_slot((k % 2 == 0) ? "R9" : "R10", $urandom_range(0, 3));
        end

        wait (sb_q.size() == 0);
        #1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule